// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog peripheral behind a simple 32-bit register port. Software sets a reload value and a prescale divisor, then turns the timer on. A free-running microsecond strobe from outside feeds a prescaler. Each time the prescaler wraps, a 16-bit down-counter drops by one. If software does not restart the counter in time, the counter reaches zero while the timer is on. The block then raises a single-cycle system reset request and latches a reset-cause bit.

The restart ("kick") is a write to its own register, separate from the control word. The cause bit sits in a system-status word. A system reset, which is what the request normally leads to, leaves the cause bit alone. Only a power-on reset or an explicit write-one-to-clear removes it, so boot code can see why the chip restarted. The control word can be read back, which lets software spot a timer that an earlier stage left running.

Top module: `wdog_timer`

## Requirements
- R1: After power-on reset the control word (0x20) reads 0, the load word (0x24) reads 0x0000FFFF, the system-status word (0x38) reads 0, and the reset request is low.
- R2: The control word holds the enable flag at bit 7 and the 16-bit prescale divisor at bits 31:16, and it reads back exactly those fields with all other bits zero. The load word keeps only bits 15:0, and its upper half reads zero.
- R3: A write that turns the enable bit from 0 to 1 loads the counter from the load word and clears the prescaler phase. While enabled, the counter drops by one after every D base-tick strobes, where D is the divisor and a divisor of 0 counts as 1.
- R4: A write to offset 0x00 with bit 9 set reloads the counter from the load word and clears the prescaler phase. A write there with bit 9 clear has no effect, and offset 0x00 always reads 0.
- R5: When the counter is zero while the timer is enabled, the reset request goes high for exactly one cycle, in the cycle after the counter reaches zero. No further request is made until the counter is reloaded, and no request is ever made while the timer is disabled.
- R6: Clearing the enable bit freezes the counter and the prescaler. Enabling again reloads the counter.
- R7: A reset request sets bit 1 of the system-status word (0x38). The system reset input does not clear this bit. Writing a word with bit 1 set to 0x38 clears it, a write with bit 1 clear leaves it, and power-on reset clears it.
- R8: Writes to any offset other than 0x00, 0x20, 0x24 and 0x38 change nothing, and reads of such offsets return 0.
- R9: The system reset input returns the enable bit, the divisor, the load word and the counter to their power-on values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| porRstN | input | 1 | Power-on reset, active low, asynchronous; clears everything including the cause bit |
| sysRstN | input | 1 | System reset, active low, synchronous; clears the timer state but not the cause bit |
| usTick | input | 1 | One-cycle strobe marking each microsecond base tick |
| busWe | input | 1 | Write strobe for the register port |
| busAddr | input | 8 | Byte offset of the accessed word |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| wdtRstReq | output | 1 | One-cycle system reset request on expiry |

## Verification
The bench targets the edges of the count. A load of zero must fire right after the reload, and a divisor of zero must behave as divide-by-one; a design that underflows or divides by zero would wrap to a 65536-step count and miss the expiry. After one expiry the bench keeps the timer enabled for a long time to catch a design that re-fires every cycle at zero. It also disables the timer in the middle of a count to catch a counter that keeps running. Both resets are applied with the cause bit set, so a design that puts the bit in the wrong reset domain either loses it on a system reset or keeps it through power-on. Kick writes without bit 9 and writes to unmapped offsets are mixed into the traffic, and any stray reload or register change shows up as a shifted expiry cycle against the reference model.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_KICK = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_LOAD = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_SYS  = 8'h38;

  localparam int BIT_KICK  = 9;
  localparam int BIT_EN    = 7;
  localparam int DIV_LSB   = 16;
  localparam int BIT_CAUSE = 1;

  // strobes from the register block to the counting datapath
  typedef struct packed {
    logic reload;  // restart count from load word, clear phase
    logic runEn;   // timer enabled
  } wdStrobe_t;
endpackage

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              sysRstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              expirePulse,
  output wdStrobe_t         strobe,
  output logic [DIV_W-1:0]  divisor,
  output logic [CNT_W-1:0]  loadVal,
  output logic [DATA_W-1:0] busRdata
);
  logic             enReg;
  logic [DIV_W-1:0] divReg;
  logic [CNT_W-1:0] loadReg;
  logic             causeFlag;

  logic wrKick, wrCtrl, wrLoad, wrSys, clrCause;

  assign wrKick   = busWe && (busAddr == OFS_KICK) && busWdata[BIT_KICK];
  assign wrCtrl   = busWe && (busAddr == OFS_CTRL);
  assign wrLoad   = busWe && (busAddr == OFS_LOAD);
  assign wrSys    = busWe && (busAddr == OFS_SYS);
  assign clrCause = wrSys && busWdata[BIT_CAUSE];

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      enReg   <= 1'b0;
      divReg  <= '0;
      loadReg <= '1;
    end else if (!sysRstN) begin
      enReg   <= 1'b0;
      divReg  <= '0;
      loadReg <= '1;
    end else begin
      if (wrCtrl) begin
        enReg  <= busWdata[BIT_EN];
        divReg <= busWdata[DIV_LSB +: DIV_W];
      end
      if (wrLoad) loadReg <= busWdata[CNT_W-1:0];
    end
  end

  // cause bit lives only in the power-on domain
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)         causeFlag <= 1'b0;
    else if (expirePulse) causeFlag <= 1'b1;
    else if (clrCause)    causeFlag <= 1'b0;
  end

  always_comb begin
    strobe.reload = wrKick || (wrCtrl && busWdata[BIT_EN] && !enReg);
    strobe.runEn  = enReg;
  end

  assign divisor = divReg;
  assign loadVal = loadReg;

  always_comb begin
    busRdata = '0;
    case (busAddr)
      OFS_CTRL: begin
        busRdata[BIT_EN]              = enReg;
        busRdata[DIV_LSB +: DIV_W]    = divReg;
      end
      OFS_LOAD: busRdata[CNT_W-1:0]   = loadReg;
      OFS_SYS:  busRdata[BIT_CAUSE]   = causeFlag;
      default:  busRdata = '0;
    endcase
  end

  p_flag_set_r7: assert property (@(posedge clk) disable iff (!porRstN)
    expirePulse |=> causeFlag);
  p_flag_keep_r7: assert property (@(posedge clk) disable iff (!porRstN)
    (causeFlag && !clrCause) |=> causeFlag);
  p_sys_clear_r9: assert property (@(posedge clk) disable iff (!porRstN)
    !sysRstN |=> (!enReg && loadReg == '1 && divReg == '0));
endmodule

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             porRstN,
  input  logic             sysRstN,
  input  logic             usTick,
  input  wdStrobe_t        strobe,
  input  logic [DIV_W-1:0] divisor,
  input  logic [CNT_W-1:0] loadVal,
  output logic             rstReq
);
  logic [CNT_W-1:0] count;
  logic [DIV_W-1:0] phase;
  logic [DIV_W-1:0] divEff;
  logic             fired;
  logic             atZero;
  logic             wrap;

  assign divEff = (divisor == '0) ? DIV_W'(1) : divisor;
  assign wrap   = (phase >= divEff - DIV_W'(1));
  assign atZero = (count == '0);

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      count <= '0; phase <= '0; fired <= 1'b0; rstReq <= 1'b0;
    end else if (!sysRstN) begin
      count <= '0; phase <= '0; fired <= 1'b0; rstReq <= 1'b0;
    end else if (strobe.reload) begin
      count  <= loadVal;
      phase  <= '0;
      fired  <= 1'b0;
      rstReq <= 1'b0;
    end else if (strobe.runEn) begin
      rstReq <= atZero && !fired;
      if (atZero) begin
        fired <= 1'b1;
      end else if (usTick) begin
        if (wrap) begin
          phase <= '0;
          count <= count - CNT_W'(1);
        end else begin
          phase <= phase + DIV_W'(1);
        end
      end
    end else begin
      rstReq <= 1'b0;
    end
  end

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    rstReq |=> !rstReq);
  p_pulse_needs_en_r5: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    rstReq |-> $past(strobe.runEn));
  p_hold_off_r6: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    (!strobe.runEn && !strobe.reload) |=> ($stable(count) && $stable(phase)));
  p_reload_r3: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    strobe.reload |=> (count == $past(loadVal) && phase == '0));
  p_step_r3: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    (strobe.runEn && !strobe.reload) |=>
      (count == $past(count) || count == $past(count) - CNT_W'(1)));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV_W = 16
) (
  input  logic        clk,
  input  logic        porRstN,
  input  logic        sysRstN,
  input  logic        usTick,
  input  logic        busWe,
  input  logic [7:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        wdtRstReq
);
  wdStrobe_t        strobe;
  logic [DIV_W-1:0] divisor;
  logic [CNT_W-1:0] loadVal;

  wdog_ctrl #(.CNT_W(CNT_W), .DIV_W(DIV_W)) uCtrl (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN),
    .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .expirePulse(wdtRstReq), .strobe(strobe),
    .divisor(divisor), .loadVal(loadVal), .busRdata(busRdata)
  );

  wdog_datapath #(.CNT_W(CNT_W), .DIV_W(DIV_W)) uPath (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN), .usTick(usTick),
    .strobe(strobe), .divisor(divisor), .loadVal(loadVal),
    .rstReq(wdtRstReq)
  );
endmodule

// File: tb/sim_wdog_timer.sv
module sim_wdog_timer;
  logic        clk = 1'b0;
  logic        porRstN = 1'b0;
  logic        sysRstN = 1'b1;
  logic        usTick = 1'b0;
  logic        busWe = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic [31:0] busWdata = 32'h0;
  logic [31:0] busRdata;
  logic        wdtRstReq;

  int checks = 0;
  int fails = 0;
  int pulses = 0;
  bit done = 0;
  string tag = "R1";

  always #2 clk = ~clk;  // 250 MHz

  wdog_timer u0 (.*);

  // base tick: one strobe every third clock
  initial begin
    int ph = 0;
    forever begin
      @(posedge clk); #1;
      ph++;
      usTick = (ph % 3 == 0);
    end
  end

  // behavioural reference model
  int  mEn = 0, mDiv = 0, mLoad = 65535, mCnt = 0, mPre = 0;
  bit  mFired = 0, mReq = 0, mFlag = 0;

  always @(posedge clk) begin
    if (!porRstN) begin
      mEn = 0; mDiv = 0; mLoad = 65535; mCnt = 0; mPre = 0;
      mFired = 0; mReq = 0; mFlag = 0;
    end else begin
      bit oldReq;
      bit reload;
      int d;
      oldReq = mReq;
      if (oldReq) mFlag = 1;
      else if (busWe && busAddr == 8'h38 && busWdata[1]) mFlag = 0;
      if (!sysRstN) begin
        mEn = 0; mDiv = 0; mLoad = 65535; mCnt = 0; mPre = 0; mFired = 0; mReq = 0;
      end else begin
        reload = (busWe && busAddr == 8'h00 && busWdata[9]) ||
                 (busWe && busAddr == 8'h20 && busWdata[7] && mEn == 0);
        d = (mDiv == 0) ? 1 : mDiv;
        if (reload) begin
          mCnt = mLoad; mPre = 0; mFired = 0; mReq = 0;
        end else if (mEn != 0) begin
          mReq = (mCnt == 0) && !mFired;
          if (mCnt == 0) mFired = 1;
          else if (usTick) begin
            if (mPre + 1 >= d) begin mPre = 0; mCnt = mCnt - 1; end
            else mPre = mPre + 1;
          end
        end else mReq = 0;
        if (busWe && busAddr == 8'h20) begin
          mEn = busWdata[7]; mDiv = busWdata[31:16];
        end
        if (busWe && busAddr == 8'h24) mLoad = busWdata[15:0];
      end
    end
  end

  function automatic logic [31:0] mRead(logic [7:0] a);
    case (a)
      8'h20:   return {mDiv[15:0], 8'h00, mEn[0], 7'h00};
      8'h24:   return {16'h0, mLoad[15:0]};
      8'h38:   return {30'h0, mFlag, 1'b0};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the edge
  always @(negedge clk) begin
    if (porRstN && !done) begin
      chk(tag, {31'h0, wdtRstReq}, {31'h0, mReq});
      chk(tag, busRdata, mRead(busAddr));
      if (wdtRstReq) pulses++;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(posedge clk); #1;
    busAddr = a;
    @(negedge clk);
    chk(req, busRdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  function automatic logic [31:0] ctl(input int div, input bit en);
    return (32'(div) << 16) | (en ? 32'h80 : 32'h0);
  endfunction

  initial begin
    int p0;
    idle(3); #1 porRstN = 1'b1;
    // R1 reset state
    tag = "R1";
    rd(8'h20, 32'h0, "R1"); rd(8'h24, 32'h0000FFFF, "R1"); rd(8'h38, 32'h0, "R1");
    chk("R1", {31'h0, wdtRstReq}, 32'h0);
    // R2 field layout
    tag = "R2";
    wr(8'h20, 32'hFFFF_FF7F); rd(8'h20, 32'hFFFF_0000, "R2");
    wr(8'h20, 32'h0);
    wr(8'h24, 32'hABCD_1234); rd(8'h24, 32'h0000_1234, "R2");
    // R8 unmapped offsets
    tag = "R8";
    wr(8'h10, 32'hFFFF_FFFF); wr(8'h3C, 32'hFFFF_FFFF); wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h10, 32'h0, "R8"); rd(8'h3C, 32'h0, "R8");
    rd(8'h20, 32'h0, "R8"); rd(8'h24, 32'h0000_1234, "R8");
    // R3/R5 enable, count, expire
    tag = "R3";
    wr(8'h24, 32'd5); wr(8'h20, ctl(2, 1));
    idle(60);
    tag = "R5";
    chk("R5", pulses, 1);
    idle(150);
    chk("R5", pulses, 1);
    tag = "R7";
    rd(8'h38, 32'h2, "R7");
    // R4 kicks keep it alive
    tag = "R4";
    wr(8'h24, 32'd20);
    p0 = pulses;
    for (int i = 0; i < 10; i++) begin wr(8'h00, 32'h200); idle(30); end
    chk("R4", pulses, p0);
    wr(8'h00, 32'hFFFF_FDFF); wr(8'h00, 32'h0);
    rd(8'h00, 32'h0, "R4");
    idle(150);
    chk("R4", pulses, p0 + 1);
    // R3 divisor zero is divide-by-one
    tag = "R3";
    wr(8'h20, ctl(0, 0)); wr(8'h24, 32'd4); wr(8'h20, ctl(0, 1));
    idle(20);
    chk("R3", pulses, p0 + 2);
    // R6 disable freezes
    tag = "R6";
    wr(8'h24, 32'd8); wr(8'h20, ctl(1, 0)); wr(8'h20, ctl(1, 1));
    idle(10);
    wr(8'h00, 32'h200); wr(8'h20, ctl(1, 0));
    p0 = pulses;
    idle(200);
    chk("R6", pulses, p0);
    wr(8'h20, ctl(1, 1));
    idle(40);
    chk("R6", pulses, p0 + 1);
    // R5 load zero fires straight after reload
    tag = "R5";
    wr(8'h24, 32'd0); wr(8'h00, 32'h200);
    idle(4);
    chk("R5", pulses, p0 + 2);
    // R9 system reset, R7 flag survives
    tag = "R9";
    wr(8'h20, ctl(7, 1));
    @(posedge clk); #1 sysRstN = 1'b0;
    idle(2); #1 sysRstN = 1'b1;
    rd(8'h20, 32'h0, "R9"); rd(8'h24, 32'h0000FFFF, "R9");
    rd(8'h38, 32'h2, "R7");
    tag = "R7";
    wr(8'h38, 32'hFFFF_FFFD); rd(8'h38, 32'h2, "R7");
    wr(8'h38, 32'h2); rd(8'h38, 32'h0, "R7");
    // power-on clears the flag
    wr(8'h24, 32'd1); wr(8'h20, ctl(0, 1));
    idle(10);
    rd(8'h38, 32'h2, "R7");
    @(posedge clk); #1 porRstN = 1'b0;
    idle(2); #1 porRstN = 1'b1;
    rd(8'h38, 32'h0, "R7"); rd(8'h20, 32'h0, "R1");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule